// File: doc/BRIEF.md
# DAC Output Code Update Controller

This block decides when the code driven to a digital-to-analog converter channel changes. Software places a 12-bit code in a staging register. The block copies that code into the output register in one of three ways. With triggering off, the copy follows the staging register one clock later. With triggering on and a hardware source chosen, the copy waits for a rising edge on the chosen one of sixteen trigger lines. With triggering on and the software source chosen, a self-clearing request bit starts the copy.

After a copy caused by a hardware trigger, the block can raise a DMA request so that a DMA engine refills the staging register before the next trigger. The request stays up until the engine acknowledges it. The source selector is frozen while the channel is enabled, and nothing reaches the output while the channel is disabled. Reset is asynchronous, active low, and is released through a two-stage synchronizer inside the block.

Top module: `dac_xfer_ctrl`

## Requirements
- R1: After reset, out_code is 0, dma_req is 0, rd_swtrig is 0 and rd_tsel is 0.
- R2: With the channel enabled and triggering off, a staging write sampled at clock edge k appears on out_code after edge k+1.
- R3: With triggering on and a hardware source selected (rd_tsel not 0), a rising edge first sampled high at edge k on trig_in[rd_tsel] loads out_code at edge k+4 from the staging register as it stands before that edge. This is two synchronizer stages plus three clocks from the synchronized edge.
- R4: A trigger edge whose synchronized rise falls in the window from the start of a pending transfer up to and including its load edge is dropped and causes no second load.
- R5: Select code 0 is the software source. With it selected and triggering on, a software trigger request sampled at edge k sets rd_swtrig after edge k. The staging register is copied to out_code at edge k+1, and rd_swtrig reads 0 after that edge.
- R6: A software trigger request made while the channel is disabled, while triggering is off or while a hardware source is selected keeps rd_swtrig at 1 and does not change out_code.
- R7: A control write changes rd_tsel only when the channel was disabled before that write. The enable, trigger-enable and DMA-enable fields always take the written value.
- R8: When DMA is enabled, dma_req rises in the same clock as a hardware-triggered load and stays at 1 until dma_ack is sampled high. It then reads 0 after that edge unless a new hardware load happens on the same edge.
- R9: A software-triggered or direct load never raises dma_req.
- R10: While the channel is disabled, out_code holds its value. Trigger edges and staging writes cause no load and no DMA request, and a pending hardware transfer is dropped.
- R11: Pulses on trig_in[0] never cause a load, because code 0 selects the software source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_en | input | 1 | Channel enable value to write |
| ctrl_trig_en | input | 1 | Trigger enable value to write |
| ctrl_tsel | input | 4 | Trigger source select value to write (0 = software) |
| ctrl_dma_en | input | 1 | DMA enable value to write |
| sw_set | input | 1 | Write strobe that sets the software trigger bit |
| hold_we | input | 1 | Staging register write strobe |
| hold_data | input | 12 | Staging register write data |
| trig_in | input | 16 | Asynchronous hardware trigger lines |
| dma_ack | input | 1 | DMA acknowledge, clears the request |
| dma_req | output | 1 | DMA request after a hardware-triggered load |
| out_code | output | 12 | Output data code to the converter |
| rd_tsel | output | 4 | Readback of the active trigger select |
| rd_swtrig | output | 1 | Readback of the software trigger bit |

## Verification
A wrong pending counter or synchronizer depth shows at out_code as a load one or more clocks early or late after a trigger edge. Because the bench model compares every clock, such an error is caught at the first traced trigger. A pending flag that fails to block a second edge shows as a later reload with a staging value that was changed on purpose in between. A stuck software bit or request flag shows on rd_swtrig or dma_req within one clock of the load that should have cleared it or must not have set it.

// File: rtl/dac_xfer_pkg.sv
package dac_xfer_pkg;

  localparam int DEF_CODE_W   = 12;
  localparam int DEF_NUM_TRIG = 16;
  localparam int DEF_HW_LAT   = 3;
  localparam int DEF_SYNC     = 2;
  localparam int DEF_SW_SEL   = 0;

  // Reason the output register takes a new code in a given cycle
  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_DIRECT = 2'd1,
    SRC_HW     = 2'd2,
    SRC_SW     = 2'd3
  } load_src_e;

endpackage

// File: rtl/dac_trig_sync.sv
module dac_trig_sync #(
  parameter int NUM_TRIG = 16,
  parameter int SEL_W    = 4,
  parameter int STAGES   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_TRIG-1:0] trig_in,
  input  logic [SEL_W-1:0]    sel,
  output logic                rise
);

  localparam int DEPTH = STAGES + 1;

  logic             picked;
  logic [DEPTH-1:0] chain_q;
  logic [DEPTH-1:0] chain_d;

  assign picked = trig_in[sel];

  // Synchronizer stages plus one delay stage for edge detection
  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_stage
      if (g == 0) begin : g_first
        assign chain_d[g] = picked;
      end else begin : g_next
        assign chain_d[g] = chain_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];

  // R3: a detected rise lasts exactly one cycle
  assert_rise_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise)
    else $error("rise held for more than one cycle");

endmodule

// File: rtl/dac_xfer_seq.sv
module dac_xfer_seq
  import dac_xfer_pkg::*;
#(
  parameter int SEL_W  = 4,
  parameter int HW_LAT = 3,
  parameter int SW_SEL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             trig_en,
  input  logic [SEL_W-1:0] tsel,
  input  logic             hw_rise,
  input  logic             sw_set,
  output load_src_e        load_src,
  output logic             swtrig
);

  localparam int                CNT_W    = (HW_LAT > 2) ? $clog2(HW_LAT) : 1;
  localparam logic [CNT_W-1:0]  CNT_LOAD = CNT_W'(HW_LAT - 1);
  localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(1);
  localparam logic [SEL_W-1:0]  SW_CODE  = SEL_W'(SW_SEL);

  logic             pend_q,  pend_d;
  logic [CNT_W-1:0] cnt_q,   cnt_d;
  logic             swbit_q, swbit_d;
  logic             active;
  logic             sw_sel;
  logic             hw_fire;
  logic             sw_fire;
  load_src_e        src;

  assign active  = en & trig_en;
  assign sw_sel  = (tsel == SW_CODE);
  assign hw_fire = active & pend_q & (cnt_q == CNT_LAST);
  assign sw_fire = active & sw_sel & swbit_q;

  always_comb begin
    if (!en) begin
      src = SRC_NONE;
    end else if (!trig_en) begin
      src = SRC_DIRECT;
    end else if (hw_fire) begin
      src = SRC_HW;
    end else if (sw_fire) begin
      src = SRC_SW;
    end else begin
      src = SRC_NONE;
    end
  end

  // Pending hardware transfer: armed on a synchronized rise, fires when the count hits one
  always_comb begin
    pend_d = pend_q;
    cnt_d  = cnt_q;
    if (!active) begin
      pend_d = 1'b0;
      cnt_d  = '0;
    end else if (pend_q) begin
      if (hw_fire) begin
        pend_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end else if (hw_rise && !sw_sel) begin
      pend_d = 1'b1;
      cnt_d  = CNT_LOAD;
    end
  end

  // Software trigger bit: set by a write, cleared by its own load
  always_comb begin
    swbit_d = sw_set | (swbit_q & ~sw_fire);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      cnt_q   <= '0;
      swbit_q <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      cnt_q   <= cnt_d;
      swbit_q <= swbit_d;
    end
  end

  assign load_src = src;
  assign swtrig   = swbit_q;

  // R10: no load of any kind while the channel is off
  assert_no_load_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (load_src == SRC_NONE))
    else $error("load while disabled");

  // R5: a software-triggered load clears the request bit
  assert_sw_self_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((load_src == SRC_SW) && !sw_set) |=> !swtrig)
    else $error("software trigger bit not cleared");

  // R4: the pending window never runs longer than the latency
  assert_pend_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> ((cnt_q >= CNT_LAST) && (cnt_q <= CNT_LOAD)))
    else $error("pending counter out of range");

  // R11: a hardware load never happens with the software code selected
  assert_hw_not_sw_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (load_src == SRC_HW) |-> (tsel != SW_CODE))
    else $error("hardware load with software source");

endmodule

// File: rtl/dac_dma_req.sv
module dac_dma_req (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic ack,
  output logic req
);

  logic req_q, req_d;

  always_comb begin
    req_d = req_q;
    if (set) begin
      req_d = 1'b1;
    end else if (ack) begin
      req_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
    end else begin
      req_q <= req_d;
    end
  end

  assign req = req_q;

  // R8: request stays up until acknowledged
  assert_req_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !ack) |=> req_q)
    else $error("request dropped without acknowledge");

  // R8: request only rises because of a completed hardware load
  assert_req_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> $past(set))
    else $error("request rose without a load");

endmodule

// File: rtl/dac_xfer_ctrl.sv
module dac_xfer_ctrl
  import dac_xfer_pkg::*;
#(
  parameter int CODE_W   = DEF_CODE_W,
  parameter int NUM_TRIG = DEF_NUM_TRIG,
  parameter int HW_LAT   = DEF_HW_LAT,
  parameter int SYNC     = DEF_SYNC,
  parameter int SW_SEL   = DEF_SW_SEL,
  localparam int SEL_W   = $clog2(NUM_TRIG)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctrl_we,
  input  logic                ctrl_en,
  input  logic                ctrl_trig_en,
  input  logic [SEL_W-1:0]    ctrl_tsel,
  input  logic                ctrl_dma_en,
  input  logic                sw_set,
  input  logic                hold_we,
  input  logic [CODE_W-1:0]   hold_data,
  input  logic [NUM_TRIG-1:0] trig_in,
  input  logic                dma_ack,
  output logic                dma_req,
  output logic [CODE_W-1:0]   out_code,
  output logic [SEL_W-1:0]    rd_tsel,
  output logic                rd_swtrig
);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_i = rst_sync_q[1];

  // Control, staging and output registers
  logic              en_q,   en_d;
  logic              te_q,   te_d;
  logic              dma_q,  dma_d;
  logic [SEL_W-1:0]  tsel_q, tsel_d;
  logic [CODE_W-1:0] hold_q, hold_d;
  logic [CODE_W-1:0] out_q,  out_d;

  logic              hw_rise;
  logic              swtrig;
  logic              dma_set;
  load_src_e         load_src;

  always_comb begin
    en_d   = en_q;
    te_d   = te_q;
    dma_d  = dma_q;
    tsel_d = tsel_q;
    if (ctrl_we) begin
      en_d  = ctrl_en;
      te_d  = ctrl_trig_en;
      dma_d = ctrl_dma_en;
      if (!en_q) begin
        tsel_d = ctrl_tsel;
      end
    end
  end

  always_comb begin
    hold_d = hold_we ? hold_data : hold_q;
  end

  always_comb begin
    out_d = (load_src != SRC_NONE) ? hold_q : out_q;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      en_q   <= 1'b0;
      te_q   <= 1'b0;
      dma_q  <= 1'b0;
      tsel_q <= '0;
      hold_q <= '0;
      out_q  <= '0;
    end else begin
      en_q   <= en_d;
      te_q   <= te_d;
      dma_q  <= dma_d;
      tsel_q <= tsel_d;
      hold_q <= hold_d;
      out_q  <= out_d;
    end
  end

  dac_trig_sync #(
    .NUM_TRIG (NUM_TRIG),
    .SEL_W    (SEL_W),
    .STAGES   (SYNC)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_i),
    .trig_in (trig_in),
    .sel     (tsel_q),
    .rise    (hw_rise)
  );

  dac_xfer_seq #(
    .SEL_W  (SEL_W),
    .HW_LAT (HW_LAT),
    .SW_SEL (SW_SEL)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_i),
    .en       (en_q),
    .trig_en  (te_q),
    .tsel     (tsel_q),
    .hw_rise  (hw_rise),
    .sw_set   (sw_set),
    .load_src (load_src),
    .swtrig   (swtrig)
  );

  assign dma_set = (load_src == SRC_HW) & dma_q;

  dac_dma_req u_dma (
    .clk   (clk),
    .rst_n (rst_i),
    .set   (dma_set),
    .ack   (dma_ack),
    .req   (dma_req)
  );

  assign out_code  = out_q;
  assign rd_tsel   = tsel_q;
  assign rd_swtrig = swtrig;

  // R7: selector frozen across cycles where the channel stays enabled
  assert_tsel_locked_R7: assert property (@(posedge clk) disable iff (!rst_i)
    (en_q && $past(en_q)) |-> $stable(tsel_q))
    else $error("trigger select changed while enabled");

  // R2: direct path copies the staging value present before the edge
  assert_direct_follow_R2: assert property (@(posedge clk) disable iff (!rst_i)
    (load_src == SRC_DIRECT) |=> (out_q == $past(hold_q)))
    else $error("direct copy mismatch");

  // R9: software and direct loads never start a DMA request
  assert_no_dma_sw_R9: assert property (@(posedge clk) disable iff (!rst_i)
    ((load_src == SRC_SW) || (load_src == SRC_DIRECT)) |=> !$rose(dma_req))
    else $error("DMA request after non-hardware load");

  // R10: output frozen while the channel is off
  assert_out_hold_R10: assert property (@(posedge clk) disable iff (!rst_i)
    !en_q |=> (out_q == $past(out_q)))
    else $error("output changed while disabled");

endmodule

// File: tb/dac_xfer_ctrl_test.sv
module dac_xfer_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int CW = 12;
  localparam int NT = 16;
  localparam int SW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ctrl_we, ctrl_en, ctrl_trig_en, ctrl_dma_en;
  logic [SW-1:0] ctrl_tsel;
  logic          sw_set, hold_we, dma_ack;
  logic [CW-1:0] hold_data;
  logic [NT-1:0] trig_in;
  logic          dma_req, rd_swtrig;
  logic [CW-1:0] out_code;
  logic [SW-1:0] rd_tsel;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_xfer_ctrl uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctrl_we      (ctrl_we),
    .ctrl_en      (ctrl_en),
    .ctrl_trig_en (ctrl_trig_en),
    .ctrl_tsel    (ctrl_tsel),
    .ctrl_dma_en  (ctrl_dma_en),
    .sw_set       (sw_set),
    .hold_we      (hold_we),
    .hold_data    (hold_data),
    .trig_in      (trig_in),
    .dma_ack      (dma_ack),
    .dma_req      (dma_req),
    .out_code     (out_code),
    .rd_tsel      (rd_tsel),
    .rd_swtrig    (rd_swtrig)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int  m_out, m_hold, m_tsel, m_cyc, m_due;
  bit  m_en, m_te, m_dma, m_sw, m_req, m_valid;
  bit  hist[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_out = 0; m_hold = 0; m_tsel = 0; m_cyc = 0; m_due = -1;
      m_en = 0; m_te = 0; m_dma = 0; m_sw = 0; m_req = 0;
      hist = '{0, 0, 0};
      m_valid = 1;
    end else if (m_valid) begin
      bit x, rise, fire, swfire, was_pending, ld;
      x = trig_in[m_tsel];
      rise = hist[1] && !hist[0];
      was_pending = (m_due >= 0);
      fire = (m_due == m_cyc) && m_en && m_te;
      swfire = m_sw && m_en && m_te && (m_tsel == 0);
      ld = m_en && (!m_te || fire || swfire);
      if (ld) m_out = m_hold;
      if (fire && m_dma) m_req = 1;
      else if (dma_ack) m_req = 0;
      m_sw = sw_set || (m_sw && !swfire);
      if (fire || !(m_en && m_te)) m_due = -1;
      else if (!was_pending && rise && m_tsel != 0) m_due = m_cyc + 2;
      if (ctrl_we) begin
        if (!m_en) m_tsel = int'(ctrl_tsel);
        m_en = ctrl_en; m_te = ctrl_trig_en; m_dma = ctrl_dma_en;
      end
      if (hold_we) m_hold = int'(hold_data);
      hist.push_back(x);
      void'(hist.pop_front());
      m_cyc++;
    end
  end

  // Every-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && m_valid) begin
      chk("out_code R2 R3 R4 R10", int'(out_code), m_out);
      chk("dma_req R8 R9", int'(dma_req), int'(m_req));
      chk("rd_tsel R7", int'(rd_tsel), m_tsel);
      chk("rd_swtrig R5 R6", int'(rd_swtrig), int'(m_sw));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic ctrl_wr(input bit en, input bit te, input int tsel, input bit dma);
    @(negedge clk);
    ctrl_we = 1; ctrl_en = en; ctrl_trig_en = te; ctrl_tsel = SW'(tsel); ctrl_dma_en = dma;
    @(negedge clk);
    ctrl_we = 0;
  endtask

  task automatic hold_wr(input int v);
    @(negedge clk);
    hold_we = 1; hold_data = CW'(v);
    @(negedge clk);
    hold_we = 0;
  endtask

  task automatic ack_pulse();
    @(negedge clk);
    dma_ack = 1;
    @(negedge clk);
    dma_ack = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 0; ctrl_we = 0; ctrl_en = 0; ctrl_trig_en = 0; ctrl_tsel = '0; ctrl_dma_en = 0;
    sw_set = 0; hold_we = 0; hold_data = '0; trig_in = '0; dma_ack = 0;
    idle(3);
    rst_n = 1;
    idle(4);
    // R1 reset state
    chk("R1 out_code", int'(out_code), 0);
    chk("R1 dma_req", int'(dma_req), 0);
    chk("R1 rd_swtrig", int'(rd_swtrig), 0);
    chk("R1 rd_tsel", int'(rd_tsel), 0);

    // R2 direct path
    ctrl_wr(1, 0, 5, 0);
    chk("R7 tsel writable while disabled", int'(rd_tsel), 5);
    hold_wr('h2B7);
    @(negedge clk);
    chk("R2 direct copy", int'(out_code), 'h2B7);

    // R7 lock, R3 hardware latency, R8 DMA request
    ctrl_wr(1, 1, 9, 1);
    chk("R7 tsel locked", int'(rd_tsel), 5);
    hold_wr('h7FF);
    @(negedge clk); trig_in[5] = 1;
    idle(2); trig_in[5] = 0;
    idle(2);
    chk("R3 not yet loaded", int'(out_code), 'h2B7);
    @(negedge clk);
    chk("R3 loaded at latency", int'(out_code), 'h7FF);
    chk("R8 request raised", int'(dma_req), 1);
    idle(5);
    chk("R8 request held", int'(dma_req), 1);
    ack_pulse();
    chk("R8 request cleared by ack", int'(dma_req), 0);

    // R4 edge during pending transfer dropped
    hold_wr('h100);
    @(negedge clk); trig_in[5] = 1;
    @(negedge clk); trig_in[5] = 0;
    @(negedge clk); trig_in[5] = 1;
    @(negedge clk); trig_in[5] = 0;
    @(negedge clk); hold_we = 1; hold_data = CW'('h3AA);
    @(negedge clk); hold_we = 0;
    chk("R4 first edge loaded", int'(out_code), 'h100);
    idle(4);
    chk("R4 second edge ignored", int'(out_code), 'h100);
    ack_pulse();

    // R10 disabled channel
    ctrl_wr(0, 1, 5, 1);
    @(negedge clk); trig_in[5] = 1;
    idle(2); trig_in[5] = 0;
    idle(5);
    chk("R10 no load when off", int'(out_code), 'h100);
    chk("R10 no request when off", int'(dma_req), 0);
    ctrl_wr(0, 0, 5, 1);
    hold_wr('h0AB);
    idle(3);
    chk("R10 staging write not copied", int'(out_code), 'h100);

    // R6 software bit waits while off
    @(negedge clk); sw_set = 1;
    @(negedge clk); sw_set = 0;
    idle(3);
    chk("R6 bit stays set", int'(rd_swtrig), 1);
    chk("R6 no load", int'(out_code), 'h100);
    ctrl_wr(0, 1, 0, 1);
    chk("R7 tsel unlocked", int'(rd_tsel), 0);
    ctrl_wr(1, 1, 0, 1);
    @(negedge clk);
    chk("R5 pending bit fires on enable", int'(out_code), 'h0AB);
    chk("R5 bit cleared", int'(rd_swtrig), 0);
    chk("R9 no request on software load", int'(dma_req), 0);

    // R5 software trigger timing
    hold_wr('h9C4);
    @(negedge clk); sw_set = 1;
    @(negedge clk); sw_set = 0;
    chk("R5 bit set", int'(rd_swtrig), 1);
    chk("R5 not yet loaded", int'(out_code), 'h0AB);
    @(negedge clk);
    chk("R5 loaded one clock later", int'(out_code), 'h9C4);
    chk("R5 bit self-cleared", int'(rd_swtrig), 0);
    chk("R9 no request", int'(dma_req), 0);

    // R11 trigger line 0 never fires
    hold_wr('h555);
    @(negedge clk); trig_in[0] = 1;
    idle(2); trig_in[0] = 0;
    idle(6);
    chk("R11 line 0 ignored", int'(out_code), 'h9C4);
    chk("R11 no request", int'(dma_req), 0);

    // Mixed traffic compared by the model every clock
    ctrl_wr(0, 1, 3, 1);
    ctrl_wr(1, 1, 3, 1);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      hold_we   = ($urandom % 4) == 0;
      hold_data = CW'($urandom);
      if (($urandom % 3) == 0) trig_in = trig_in ^ (NT'(1) << ($urandom % NT));
      dma_ack = ($urandom % 8) == 0;
      sw_set  = ($urandom % 10) == 0;
      ctrl_we = ($urandom % 60) == 0;
      ctrl_en = ($urandom % 5) != 0;
      ctrl_trig_en = ($urandom % 4) != 0;
      ctrl_tsel = SW'($urandom);
      ctrl_dma_en = $urandom % 2;
    end
    @(negedge clk);
    ctrl_we = 0; hold_we = 0; sw_set = 0; dma_ack = 0;
    idle(4);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule